// File: doc/BRIEF.md
# Banked Register Operand Collector

This block stages issued warp instructions while their source operands are read from a register file split into independent banks. Each instruction is held in a collector unit until all of its operands have been read. Each unit holds one instruction, its tag and one pending bit per source operand. The units are split into two pools: one feeds the ALU execution port and the other feeds the SFU execution port. Upstream presents an instruction with up to three source registers. The block places it in a free unit of the matching pool, or holds `in_ready` low when that pool is full.

When an instruction is accepted, each of its valid source operands is placed on the request queue of the bank that holds it. The bank is found by adding the register number to the warp number, so different warps spread across the banks. Each cycle, every bank either grants its oldest queued read or is claimed by a writeback, which always wins. The read grant is reported on the per-bank read outputs with the register, the unit and the operand slot.

A unit whose operands have all been read becomes eligible for dispatch. A round-robin picker per port sends one eligible unit per cycle to its execution port and frees that unit. The freed unit can take a new instruction in the same cycle. The register contents and the execution units lie outside this block.

Top module: `operand_collector`

## Requirements
- R1: After reset all units are free, no bank read is granted, no bank is claimed, neither port dispatches, and `in_ready` is high for both values of `in_is_sfu`.
- R2: The bank of a source register is the low log2(NUM_BANKS) bits of (register number + warp number); with 4 banks, register 1 of warp 0 lives in bank 1 and register 0 of warp 3 in bank 3.
- R3: On acceptance, each valid operand slot k (0..NUM_SRC-1) is appended to its bank's queue in ascending k, behind requests already queued, and is later reported with `rd_opnd` = k. Invalid slots queue nothing and count as already collected.
- R4: Each bank grants at most one read per cycle, always its oldest queued request. A grant drives `rd_grant[b]` with `rd_reg`, `rd_unit` (collector unit index) and `rd_opnd` for that bank, and removes the request from the queue.
- R5: A writeback (`wb_valid`) claims the bank of (`wb_reg` + `wb_warp`) for that cycle on `wr_claim`. That bank grants no read in that cycle, and its queued requests stay queued in order.
- R6: An operand's pending bit clears at the edge that ends its grant cycle. A unit may dispatch from the cycle after its last grant, or from the cycle after acceptance when it has no valid operands.
- R7: Each port dispatches at most one unit per cycle. The search starts at the unit after that port's previously dispatched unit and wraps around; after reset it starts at the lowest unit of the pool. The dispatched instruction's tag appears on `alu_tag` or `sfu_tag`, and the unit becomes free.
- R8: Units 0..NUM_ALU-1 take instructions with `in_is_sfu`=0 and dispatch only on `alu_valid`. Units NUM_ALU..NUM_ALU+NUM_SFU-1 take `in_is_sfu`=1 and dispatch only on `sfu_valid`.
- R9: `in_ready` is high exactly when a unit of the requested pool is free or is dispatching in this cycle. An accepted instruction takes the lowest-index such unit. An instruction presented while `in_ready` is low is dropped and queues no reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| in_is_sfu | input | 1 | 0: ALU pool, 1: SFU pool |
| in_warp | input | WARP_W | Warp number of the instruction |
| in_tag | input | TAG_W | Instruction tag returned at dispatch |
| in_src_valid | input | NUM_SRC | Per-slot source operand present |
| in_src_reg | input | NUM_SRC*REG_W | Source register numbers, slot k at bits k*REG_W |
| in_ready | output | 1 | A unit of the requested pool can take the instruction |
| wb_valid | input | 1 | Writeback to the register file this cycle |
| wb_warp | input | WARP_W | Warp number of the writeback |
| wb_reg | input | REG_W | Register number of the writeback |
| rd_grant | output | NUM_BANKS | Read granted on each bank |
| rd_reg | output | NUM_BANKS*REG_W | Register read on each bank |
| rd_unit | output | NUM_BANKS*UW | Collector unit receiving each bank's read |
| rd_opnd | output | NUM_BANKS*OPW | Operand slot receiving each bank's read |
| wr_claim | output | NUM_BANKS | Bank claimed by the writeback |
| alu_valid | output | 1 | ALU port dispatch |
| alu_tag | output | TAG_W | Tag of the ALU dispatch |
| sfu_valid | output | 1 | SFU port dispatch |
| sfu_tag | output | TAG_W | Tag of the SFU dispatch |

## Verification
The assertions take for granted that every input carries a defined value after reset and that at most one writeback arrives per cycle. They also rely on bank queues being filled only by accepted instructions, so that one queue never holds more than one entry per operand slot of each unit. The stimulus drives every input on every cycle and presents instructions freely, including while `in_ready` is low. It aims writebacks at any bank, and it uses directed runs that pile all three operands on one bank, hold a bank claimed across several cycles, and fill a whole pool. Between these runs, random traffic mixes both pools, sparse and full operand sets, and random warps.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int OC_BANKS     = 4;
    localparam int OC_ALU_UNITS = 2;
    localparam int OC_SFU_UNITS = 2;
    localparam int OC_SRCS      = 3;
    localparam int OC_REG_W     = 6;
    localparam int OC_WARP_W    = 5;
    localparam int OC_TAG_W     = 8;

    typedef enum logic [0:0] {
        PORT_ALU = 1'b0,
        PORT_SFU = 1'b1
    } oc_port_e;
endpackage

// File: rtl/oc_rr_pick.sv
module oc_rr_pick #(
    parameter int N = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // the candidate closest after 'last' is written last and therefore wins
    always_comb begin
        int c;
        hit = 1'b0;
        idx = last;
        for (int i = N; i >= 1; i--) begin
            c = (int'(last) + i) % N;
            if (req[c]) begin
                hit = 1'b1;
                idx = IW'(c);
            end
        end
    end
endmodule

// File: rtl/oc_bank_queue.sv
module oc_bank_queue #(
    parameter int DEPTH  = 12,
    parameter int PUSH_N = 3,
    parameter int EW     = 10,
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PUSH_N-1:0]    push_vld,
    input  logic [PUSH_N*EW-1:0] push_data,
    input  logic                 pop,
    output logic                 head_vld,
    output logic [EW-1:0]        head_data
);
    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] slot;
        logic [CW-1:0]            cnt;
    } qst_t;

    qst_t s_d, s_q;

    always_comb begin
        int n;
        s_d = s_q;
        n   = int'(s_q.cnt);
        if (pop && n != 0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                s_d.slot[i] = s_q.slot[i+1];
            end
            s_d.slot[DEPTH-1] = '0;
            n = n - 1;
        end
        // appended in slot order so lower operand slots are read first
        for (int k = 0; k < PUSH_N; k++) begin
            if (push_vld[k]) begin
                if (n < DEPTH) begin
                    s_d.slot[IXW'(n)] = push_data[k*EW +: EW];
                end
                n = n + 1;
            end
        end
        s_d.cnt = CW'(n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_vld  = (s_q.cnt != '0);
    assign head_data = s_q.slot[0];

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(s_q.cnt) + $countones(push_vld) - ((pop && s_q.cnt != '0) ? 1 : 0)) <= DEPTH);

    assert_pop_needs_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_vld);
endmodule

// File: rtl/operand_collector.sv
module operand_collector
    import oc_pkg::*;
#(
    parameter int NUM_BANKS = OC_BANKS,
    parameter int NUM_ALU   = OC_ALU_UNITS,
    parameter int NUM_SFU   = OC_SFU_UNITS,
    parameter int NUM_SRC   = OC_SRCS,
    parameter int REG_W     = OC_REG_W,
    parameter int WARP_W    = OC_WARP_W,
    parameter int TAG_W     = OC_TAG_W,
    localparam int NU  = NUM_ALU + NUM_SFU,
    localparam int UW  = (NU > 1) ? $clog2(NU) : 1,
    localparam int OPW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_is_sfu,
    input  logic [WARP_W-1:0]        in_warp,
    input  logic [TAG_W-1:0]         in_tag,
    input  logic [NUM_SRC-1:0]       in_src_valid,
    input  logic [NUM_SRC*REG_W-1:0] in_src_reg,
    output logic                     in_ready,
    input  logic                     wb_valid,
    input  logic [WARP_W-1:0]        wb_warp,
    input  logic [REG_W-1:0]         wb_reg,
    output logic [NUM_BANKS-1:0]     rd_grant,
    output logic [NUM_BANKS*REG_W-1:0] rd_reg,
    output logic [NUM_BANKS*UW-1:0]  rd_unit,
    output logic [NUM_BANKS*OPW-1:0] rd_opnd,
    output logic [NUM_BANKS-1:0]     wr_claim,
    output logic                     alu_valid,
    output logic [TAG_W-1:0]         alu_tag,
    output logic                     sfu_valid,
    output logic [TAG_W-1:0]         sfu_tag
);
    localparam int BW     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int EW     = UW + OPW + REG_W;
    localparam int QDEPTH = NU * NUM_SRC;
    localparam int AIW    = (NUM_ALU > 1) ? $clog2(NUM_ALU) : 1;
    localparam int SIW    = (NUM_SFU > 1) ? $clog2(NUM_SFU) : 1;

    typedef struct packed {
        logic [NU-1:0]                busy;
        logic [NU-1:0][NUM_SRC-1:0]   pend;
        logic [NU-1:0][TAG_W-1:0]     tag;
        logic [AIW-1:0]               last_alu;
        logic [SIW-1:0]               last_sfu;
    } ust_t;

    ust_t s_d, s_q;

    function automatic logic [BW-1:0] bank_of(input logic [REG_W-1:0] r,
                                              input logic [WARP_W-1:0] w);
        logic [31:0] sum;
        sum = 32'(r) + 32'(w);
        return sum[BW-1:0];
    endfunction

    logic [NUM_BANKS-1:0]               wb_hit;
    logic [NUM_BANKS-1:0]               q_pop;
    logic [NUM_BANKS-1:0]               q_head_vld;
    logic [NUM_BANKS-1:0][EW-1:0]       q_head;
    logic [NUM_BANKS-1:0][NUM_SRC-1:0]  q_push;
    logic [NUM_SRC-1:0][EW-1:0]         src_entry;
    logic [NUM_SRC-1:0][BW-1:0]         src_bank;
    logic [NU-1:0]                      unit_ready;
    logic [NU-1:0]                      disp_vec;
    logic [NU-1:0]                      free_vec;
    logic [BW-1:0]                      wb_bank;
    logic                               alu_hit, sfu_hit;
    logic [AIW-1:0]                     alu_idx;
    logic [SIW-1:0]                     sfu_idx;
    logic                               pool_free;
    logic                               accept;
    logic [UW-1:0]                      alloc_idx;

    // bank claim and read grant, unit readiness (all from registered state)
    always_comb begin
        wb_bank = bank_of(wb_reg, wb_warp);
        for (int b = 0; b < NUM_BANKS; b++) begin
            wb_hit[b] = wb_valid && (wb_bank == BW'(b));
            q_pop[b]  = q_head_vld[b] && !wb_hit[b];
        end
        for (int u = 0; u < NU; u++) begin
            unit_ready[u] = s_q.busy[u] && (s_q.pend[u] == '0);
        end
    end

    oc_rr_pick #(.N(NUM_ALU)) u_alu_pick (
        .req  (unit_ready[NUM_ALU-1:0]),
        .last (s_q.last_alu),
        .hit  (alu_hit),
        .idx  (alu_idx)
    );

    oc_rr_pick #(.N(NUM_SFU)) u_sfu_pick (
        .req  (unit_ready[NU-1:NUM_ALU]),
        .last (s_q.last_sfu),
        .hit  (sfu_hit),
        .idx  (sfu_idx)
    );

    // allocation, operand enqueue and next state
    always_comb begin
        s_d       = s_q;
        disp_vec  = '0;
        if (alu_hit) disp_vec[alu_idx] = 1'b1;
        if (sfu_hit) disp_vec[NUM_ALU + int'(sfu_idx)] = 1'b1;
        free_vec  = ~s_q.busy | disp_vec;

        pool_free = 1'b0;
        alloc_idx = '0;
        if (oc_port_e'(in_is_sfu) == PORT_SFU) begin
            for (int i = NU - 1; i >= NUM_ALU; i--) begin
                if (free_vec[i]) begin
                    pool_free = 1'b1;
                    alloc_idx = UW'(i);
                end
            end
        end else begin
            for (int i = NUM_ALU - 1; i >= 0; i--) begin
                if (free_vec[i]) begin
                    pool_free = 1'b1;
                    alloc_idx = UW'(i);
                end
            end
        end
        accept = in_valid && pool_free;

        for (int k = 0; k < NUM_SRC; k++) begin
            src_bank[k]  = bank_of(in_src_reg[k*REG_W +: REG_W], in_warp);
            src_entry[k] = {alloc_idx, OPW'(k), in_src_reg[k*REG_W +: REG_W]};
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                q_push[b][k] = accept && in_src_valid[k] && (src_bank[k] == BW'(b));
            end
        end

        for (int b = 0; b < NUM_BANKS; b++) begin
            if (q_pop[b]) begin
                s_d.pend[q_head[b][REG_W+OPW +: UW]][q_head[b][REG_W +: OPW]] = 1'b0;
            end
        end
        if (alu_hit) begin
            s_d.busy[alu_idx] = 1'b0;
            s_d.last_alu      = alu_idx;
        end
        if (sfu_hit) begin
            s_d.busy[NUM_ALU + int'(sfu_idx)] = 1'b0;
            s_d.last_sfu                      = sfu_idx;
        end
        if (accept) begin
            s_d.busy[alloc_idx] = 1'b1;
            s_d.pend[alloc_idx] = in_src_valid;
            s_d.tag[alloc_idx]  = in_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.last_alu <= AIW'(NUM_ALU - 1);
            s_q.last_sfu <= SIW'(NUM_SFU - 1);
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        oc_bank_queue #(
            .DEPTH  (QDEPTH),
            .PUSH_N (NUM_SRC),
            .EW     (EW)
        ) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_vld  (q_push[b]),
            .push_data (src_entry),
            .pop       (q_pop[b]),
            .head_vld  (q_head_vld[b]),
            .head_data (q_head[b])
        );

        assign rd_reg[b*REG_W +: REG_W] = q_head[b][REG_W-1:0];
        assign rd_opnd[b*OPW +: OPW]    = q_head[b][REG_W +: OPW];
        assign rd_unit[b*UW +: UW]      = q_head[b][REG_W+OPW +: UW];

        assert_grant_to_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
            q_pop[b] |-> (s_q.busy[q_head[b][REG_W+OPW +: UW]] &&
                          s_q.pend[q_head[b][REG_W+OPW +: UW]][q_head[b][REG_W +: OPW]]));
    end

    assign rd_grant  = q_pop;
    assign wr_claim  = wb_hit;
    assign in_ready  = pool_free;
    assign alu_valid = alu_hit;
    assign alu_tag   = s_q.tag[alu_idx];
    assign sfu_valid = sfu_hit;
    assign sfu_tag   = s_q.tag[NUM_ALU + int'(sfu_idx)];

    assert_wb_one_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($countones(wr_claim) == 1));

    assert_alloc_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> s_q.busy[$past(alloc_idx)]);

    assert_alu_stall_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && !in_is_sfu) |-> (&s_q.busy[NUM_ALU-1:0]));

    assert_sfu_stall_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && in_is_sfu) |-> (&s_q.busy[NU-1:NUM_ALU]));
endmodule

// File: tb/operand_collector_tb.sv
`timescale 1ns/1ps
module operand_collector_tb;
    localparam int NB = 4;
    localparam int NP = 2;
    localparam int NU = 4;
    localparam int NS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid, in_is_sfu;
    logic [4:0]  in_warp;
    logic [7:0]  in_tag;
    logic [2:0]  in_src_valid;
    logic [17:0] in_src_reg;
    logic        in_ready;
    logic        wb_valid;
    logic [4:0]  wb_warp;
    logic [5:0]  wb_reg;
    logic [3:0]  rd_grant, wr_claim;
    logic [23:0] rd_reg;
    logic [7:0]  rd_unit, rd_opnd;
    logic        alu_valid, sfu_valid;
    logic [7:0]  alu_tag, sfu_tag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int m_busy[NU];
    int m_pend[NU][NS];
    int m_tag[NU];
    int m_last[2];
    int q_unit[NB][$];
    int q_op[NB][$];
    int q_reg[NB][$];

    always #4 clk = ~clk;

    operand_collector u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_sfu(in_is_sfu),
        .in_warp(in_warp), .in_tag(in_tag), .in_src_valid(in_src_valid),
        .in_src_reg(in_src_reg), .in_ready(in_ready), .wb_valid(wb_valid),
        .wb_warp(wb_warp), .wb_reg(wb_reg), .rd_grant(rd_grant), .rd_reg(rd_reg),
        .rd_unit(rd_unit), .rd_opnd(rd_opnd), .wr_claim(wr_claim),
        .alu_valid(alu_valid), .alu_tag(alu_tag), .sfu_valid(sfu_valid), .sfu_tag(sfu_tag)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int u = 0; u < NU; u++) begin
            m_busy[u] = 0;
            m_tag[u]  = 0;
            for (int k = 0; k < NS; k++) m_pend[u][k] = 0;
        end
        m_last[0] = NP - 1;
        m_last[1] = NP - 1;
        for (int b = 0; b < NB; b++) begin
            q_unit[b].delete();
            q_op[b].delete();
            q_reg[b].delete();
        end
    endtask

    function automatic bit unit_done(input int u);
        for (int k = 0; k < NS; k++) if (m_pend[u][k] != 0) return 1'b0;
        return 1'b1;
    endfunction

    // reference step: expected outputs from model state, then advance the model
    task automatic model_cycle();
        int  pick[2];
        bit  gnt[NB];
        bit  wbh;
        int  fidx;
        int  p;
        int  bk;
        for (int b = 0; b < NB; b++) begin
            wbh = wb_valid && (((int'(wb_reg) + int'(wb_warp)) % NB) == b);
            gnt[b] = (q_unit[b].size() > 0) && !wbh;
            chk("R5", "wr_claim", 32'(wr_claim[b]), 32'(wbh));
            chk("R2", "rd_grant", 32'(rd_grant[b]), 32'(gnt[b]));
            if (gnt[b] && rd_grant[b]) begin
                chk("R4", "rd_unit", 32'(rd_unit[b*2 +: 2]), 32'(q_unit[b][0]));
                chk("R4", "rd_reg",  32'(rd_reg[b*6 +: 6]),  32'(q_reg[b][0]));
                chk("R3", "rd_opnd", 32'(rd_opnd[b*2 +: 2]), 32'(q_op[b][0]));
            end
        end
        for (int pp = 0; pp < 2; pp++) begin
            pick[pp] = -1;
            for (int i = 1; i <= NP; i++) begin
                int c;
                c = (m_last[pp] + i) % NP;
                if (pick[pp] < 0 && m_busy[pp*NP + c] != 0 && unit_done(pp*NP + c)) pick[pp] = c;
            end
        end
        chk("R6", "alu_valid", 32'(alu_valid), 32'(pick[0] >= 0));
        if (pick[0] >= 0 && alu_valid) chk("R7", "alu_tag", 32'(alu_tag), 32'(m_tag[pick[0]]));
        chk("R8", "sfu_valid", 32'(sfu_valid), 32'(pick[1] >= 0));
        if (pick[1] >= 0 && sfu_valid) chk("R7", "sfu_tag", 32'(sfu_tag), 32'(m_tag[NP + pick[1]]));

        p = in_is_sfu ? 1 : 0;
        fidx = -1;
        for (int i = NP - 1; i >= 0; i--) begin
            if (m_busy[p*NP + i] == 0 || pick[p] == i) fidx = p*NP + i;
        end
        chk("R9", "in_ready", 32'(in_ready), 32'(fidx >= 0));

        for (int b = 0; b < NB; b++) begin
            if (gnt[b]) begin
                m_pend[q_unit[b][0]][q_op[b][0]] = 0;
                void'(q_unit[b].pop_front());
                void'(q_op[b].pop_front());
                void'(q_reg[b].pop_front());
            end
        end
        for (int pp = 0; pp < 2; pp++) begin
            if (pick[pp] >= 0) begin
                m_busy[pp*NP + pick[pp]] = 0;
                m_last[pp] = pick[pp];
            end
        end
        if (in_valid && fidx >= 0) begin
            m_busy[fidx] = 1;
            m_tag[fidx]  = int'(in_tag);
            for (int k = 0; k < NS; k++) begin
                m_pend[fidx][k] = int'(in_src_valid[k]);
                if (in_src_valid[k]) begin
                    bk = (int'(in_src_reg[k*6 +: 6]) + int'(in_warp)) % NB;
                    q_unit[bk].push_back(fidx);
                    q_op[bk].push_back(k);
                    q_reg[bk].push_back(int'(in_src_reg[k*6 +: 6]));
                end
            end
        end
    endtask

    task automatic set_in(input bit v, input bit sfu, input int warp, input int tag,
                          input int sv, input int r0, input int r1, input int r2);
        in_valid     = v;
        in_is_sfu    = sfu;
        in_warp      = 5'(warp);
        in_tag       = 8'(tag);
        in_src_valid = 3'(sv);
        in_src_reg   = {6'(r2), 6'(r1), 6'(r0)};
    endtask

    task automatic set_wb(input bit v, input int warp, input int rg);
        wb_valid = v;
        wb_warp  = 5'(warp);
        wb_reg   = 6'(rg);
    endtask

    // inputs are set just after a falling edge; evaluate, then wait for the next one
    task automatic cyc();
        #1;
        model_cycle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired before the run completed");
            finish_run();
        end
    end

    initial begin
        int tagc;
        int seen;
        set_in(0, 0, 0, 0, 0, 0, 0, 0);
        set_wb(0, 0, 0);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: state right after reset
        #1;
        chk("R1", "in_ready alu", 32'(in_ready), 32'd1);
        in_is_sfu = 1'b1;
        #1;
        chk("R1", "in_ready sfu", 32'(in_ready), 32'd1);
        chk("R1", "rd_grant", 32'(rd_grant), 32'd0);
        chk("R1", "wr_claim", 32'(wr_claim), 32'd0);
        chk("R1", "alu_valid", 32'(alu_valid), 32'd0);
        chk("R1", "sfu_valid", 32'(sfu_valid), 32'd0);
        in_is_sfu = 1'b0;
        @(negedge clk);

        // R6: no operands, dispatches the next cycle
        set_in(1, 0, 0, 8'h11, 0, 0, 0, 0); cyc();
        set_in(0, 0, 0, 0, 0, 0, 0, 0);
        #1;
        chk("R6", "zero-operand dispatch", 32'(alu_valid), 32'd1);
        chk("R7", "zero-operand tag", 32'(alu_tag), 32'h11);
        model_cycle();
        @(negedge clk);

        // R3/R4: all three operands on bank 0, read in slot order
        set_in(1, 1, 0, 8'h22, 7, 0, 4, 8); cyc();
        set_in(0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) cyc();

        // R5: writeback holds bank 1 across cycles
        set_wb(1, 0, 1);
        set_in(1, 0, 0, 8'h31, 1, 1, 0, 0); cyc();
        set_in(1, 0, 0, 8'h32, 1, 1, 0, 0); cyc();
        // R9: ALU pool full, this one is dropped
        set_in(1, 0, 0, 8'h33, 7, 1, 5, 9); cyc();
        set_in(1, 1, 2, 8'h34, 0, 0, 0, 0); cyc();
        set_in(0, 0, 0, 0, 0, 0, 0, 0);
        cyc();
        set_wb(0, 0, 0);
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            #1;
            seen += int'(rd_grant[1]);
            model_cycle();
            @(negedge clk);
        end
        chk("R9", "bank1 reads after dropped request", 32'(seen), 32'd2);

        // random traffic
        tagc = 64;
        for (int i = 0; i < 3000; i++) begin
            set_in($urandom_range(0, 9) < 6, $urandom_range(0, 1), $urandom_range(0, 31),
                   tagc, $urandom_range(0, 7), $urandom_range(0, 63),
                   $urandom_range(0, 63), $urandom_range(0, 63));
            tagc = (tagc + 1) % 256;
            set_wb($urandom_range(0, 3) == 0, $urandom_range(0, 31), $urandom_range(0, 63));
            cyc();
        end
        set_in(0, 0, 0, 0, 0, 0, 0, 0);
        set_wb(0, 0, 0);
        for (int i = 0; i < 40; i++) cyc();

        done = 1'b1;
        finish_run();
    end
endmodule